// File: doc/BRIEF.md
# Triple-Voted Reset Distribution

This block turns one board-level active-low reset pin and five single-cycle reset commands into four internal resets: active-high resets for the synchronous readout logic, the delay-locked-loop state machine and the configuration logic, and an active-low reset for the analog reference. The pin and the reset-all command reach every output. Each of the four targeted commands reaches exactly one output.

Every output has its own synchronizer, clocked by the clock of the logic it resets. A request is the OR of the pin and the commands routed to that output. It sets three parallel two-stage flip-flop chains at once, without waiting for a clock edge. A majority voter combines the three chain tails, so a single upset flip-flop cannot assert or release a reset. After the voted value clears, a hold counter keeps the reset asserted for four more cycles. A final register removes glitches from the output. The reset is released synchronously, on a fixed edge of the destination clock.

Commands are level-free pulses from register outputs in the configuration clock domain. The analog reset is timed by the configuration clock. The block has no data stream, so every pin is a plain control signal.

Top module: `rst_tmr_dist`

## Requirements
- R1: While `rst_all_n` is low, `rst_sync`, `rst_dll` and `rst_cfg` are 1 and `bg_rst_n` is 0. These outputs take their asserted values as soon as the pin falls, before any clock edge.
- R2: A one-cycle pulse on `cmd_all` asserts all four resets at once, before the next clock edge.
- R3: A pulse on `cmd_sync` asserts `rst_sync` only. `rst_dll` and `rst_cfg` stay 0 and `bg_rst_n` stays 1 for the whole reset.
- R4: A pulse on `cmd_dll` asserts `rst_dll` only. Its release is timed in `clk_dll` edges.
- R5: A pulse on `cmd_cfg` asserts `rst_cfg` only.
- R6: A pulse on `cmd_bg` drives `bg_rst_n` to 0 only. The three digital resets are not affected.
- R7: Polarity: a digital reset is active when it is 1. The analog reset `bg_rst_n` is active when it is 0.
- R8: After the request for a domain is removed, that reset stays asserted through the 6th rising edge of its destination clock and is released on the 7th. This is 2 synchronizer stages, 4 hold cycles and 1 output register. A one-cycle command therefore asserts its reset for at least 4 destination cycles.
- R9: Forcing all flip-flops of any one synchronizer chain to the asserted value while no request is present leaves the reset output released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sync | input | 1 | Clock of the synchronous readout logic |
| clk_dll | input | 1 | Clock of the delay-locked-loop state machine |
| clk_cfg | input | 1 | Configuration clock; also times the analog reset |
| rst_all_n | input | 1 | Board reset pin, active low, asynchronous |
| cmd_all | input | 1 | Reset-all command pulse |
| cmd_sync | input | 1 | Readout-logic reset command pulse |
| cmd_dll | input | 1 | DLL state-machine reset command pulse |
| cmd_cfg | input | 1 | Configuration reset command pulse |
| cmd_bg | input | 1 | Analog reference reset command pulse |
| rst_sync | output | 1 | Readout-logic reset, active high |
| rst_dll | output | 1 | DLL state-machine reset, active high |
| rst_cfg | output | 1 | Configuration reset, active high |
| bg_rst_n | output | 1 | Analog reference reset, active low |

## Verification
The bench counts edges of the destination clock after each request is removed. It checks that the reset is still asserted after edge 6 and released after edge 7. A design that drops the hold counter or the output register fails this check by releasing early, and one with an extra stage fails by releasing late.

During each targeted command, the bench samples the other three resets on every cycle. This exposes a routing map that leaks one command into a neighbouring domain. It also times the DLL domain against its own, unrelated clock, which catches a synchronizer wired to the wrong clock.

Finally, the bench forces one chain fully asserted and checks that the output stays released. A voter that ORs the chains, or that reads only one of them, would assert the reset from that single upset.

// File: rtl/rst_tmr_pkg.sv
`timescale 1ns/1ps
package rst_tmr_pkg;
  localparam int NUM_DOM   = 4;
  localparam int NUM_CMD   = 5;
  localparam int NUM_CHAIN = 3;

  // output domains
  typedef enum int unsigned {
    DOM_SYNC = 0,
    DOM_DLL  = 1,
    DOM_CFG  = 2,
    DOM_BG   = 3
  } dom_e;

  // command bit positions: one per domain, then the broadcast command
  localparam int CMD_ALL = 4;

  // which commands reach a given domain
  function automatic logic [NUM_CMD-1:0] route_mask(input int dom);
    logic [NUM_CMD-1:0] m;
    m          = '0;
    m[dom]     = 1'b1;
    m[CMD_ALL] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rst_chain.sv
`timescale 1ns/1ps
module rst_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic tap
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) stage_q <= '1;
    else      stage_q <= {stage_q[STAGES-2:0], 1'b0};
  end

  assign tap = stage_q[STAGES-1];
endmodule

// File: rtl/rst_voter.sv
`timescale 1ns/1ps
module rst_voter #(
  parameter int N = 3
) (
  input  logic [N-1:0] votes,
  output logic         win
);
  localparam int HALF = N / 2;
  localparam int CW   = $clog2(N + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + CW'(votes[i]);
  end

  assign win = (int'(ones) > HALF);
endmodule

// File: rtl/tmr_rst_sync.sv
`timescale 1ns/1ps
module tmr_rst_sync #(
  parameter int STAGES = 2,
  parameter int HOLD   = 4
) (
  input  logic clk,
  input  logic req_i,
  output logic rst_o
);
  import rst_tmr_pkg::*;

  localparam int LAT = STAGES + HOLD + 1;
  localparam int HW  = $clog2(HOLD + 1);
  localparam int SW  = $clog2(LAT + 2);

  logic [NUM_CHAIN-1:0] tails;
  logic                 voted;
  logic [HW-1:0]        hold_q;
  logic                 out_q;

  for (genvar c = 0; c < NUM_CHAIN; c++) begin : g_chain
    rst_chain #(.STAGES(STAGES)) u_chain (
      .clk (clk),
      .arst(req_i),
      .tap (tails[c])
    );
  end

  rst_voter #(.N(NUM_CHAIN)) u_vote (
    .votes(tails),
    .win  (voted)
  );

  // hold counter: reloaded while the voted reset is present
  always_ff @(posedge clk or posedge req_i) begin
    if (req_i)              hold_q <= HW'(HOLD);
    else if (voted)         hold_q <= HW'(HOLD);
    else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  // glitch-free output register
  always_ff @(posedge clk or posedge req_i) begin
    if (req_i) out_q <= 1'b1;
    else       out_q <= voted | (hold_q != '0);
  end

  assign rst_o = out_q;

  // cycles since the request went away, for the release check
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or posedge req_i) begin
    if (req_i)                   since_q <= '0;
    else if (since_q != SW'(LAT + 1)) since_q <= since_q + 1'b1;
  end

  // R1 / R2: a request seen at an edge keeps the reset asserted next cycle
  a_r1_req_asserts: assert property (@(posedge clk) req_i |=> rst_o);

  // R8: release happens exactly LAT edges after the request is gone
  a_r8_release_edge: assert property (@(posedge clk) disable iff (req_i)
    $fell(rst_o) |-> (since_q == SW'(LAT)));
endmodule

// File: rtl/rst_tmr_dist.sv
`timescale 1ns/1ps
module rst_tmr_dist #(
  parameter int STAGES = 2,
  parameter int HOLD   = 4
) (
  input  logic clk_sync,
  input  logic clk_dll,
  input  logic clk_cfg,
  input  logic rst_all_n,
  input  logic cmd_all,
  input  logic cmd_sync,
  input  logic cmd_dll,
  input  logic cmd_cfg,
  input  logic cmd_bg,
  output logic rst_sync,
  output logic rst_dll,
  output logic rst_cfg,
  output logic bg_rst_n
);
  import rst_tmr_pkg::*;

  logic [NUM_CMD-1:0] cmd_vec;
  logic [NUM_DOM-1:0] dom_clk;
  logic [NUM_DOM-1:0] dom_req;
  logic [NUM_DOM-1:0] dom_rst;

  assign cmd_vec = {cmd_all, cmd_bg, cmd_cfg, cmd_dll, cmd_sync};
  assign dom_clk = {clk_cfg, clk_cfg, clk_dll, clk_sync};

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    assign dom_req[d] = !rst_all_n | (|(cmd_vec & route_mask(d)));

    tmr_rst_sync #(.STAGES(STAGES), .HOLD(HOLD)) u_sync (
      .clk  (dom_clk[d]),
      .req_i(dom_req[d]),
      .rst_o(dom_rst[d])
    );
  end

  assign rst_sync = dom_rst[DOM_SYNC];
  assign rst_dll  = dom_rst[DOM_DLL];
  assign rst_cfg  = dom_rst[DOM_CFG];
  assign bg_rst_n = !dom_rst[DOM_BG];

  // R1 / R7: pin low drives digital resets high and analog reset low
  a_r1_pin_all: assert property (@(posedge clk_cfg)
    !rst_all_n |=> (rst_cfg && !bg_rst_n));
  // R2: broadcast command
  a_r2_all_cmd: assert property (@(posedge clk_cfg) disable iff (!rst_all_n)
    cmd_all |=> (rst_cfg && !bg_rst_n));
  // R3
  a_r3_sync_cmd: assert property (@(posedge clk_sync) disable iff (!rst_all_n)
    cmd_sync |=> rst_sync);
  // R4
  a_r4_dll_cmd: assert property (@(posedge clk_dll) disable iff (!rst_all_n)
    cmd_dll |=> rst_dll);
  // R5
  a_r5_cfg_cmd: assert property (@(posedge clk_cfg) disable iff (!rst_all_n)
    cmd_cfg |=> rst_cfg);
  // R6 / R7
  a_r6_bg_cmd: assert property (@(posedge clk_cfg) disable iff (!rst_all_n)
    cmd_bg |=> !bg_rst_n);
endmodule

// File: tb/tb_rst_tmr_dist.sv
`timescale 1ns/1ps
module tb_rst_tmr_dist;
  localparam int LAT = 7;

  logic clk_sync = 1'b0, clk_dll = 1'b0, clk_cfg = 1'b0;
  logic rst_all_n = 1'b0;
  logic cmd_all = 1'b0, cmd_sync = 1'b0, cmd_dll = 1'b0, cmd_cfg = 1'b0, cmd_bg = 1'b0;
  logic rst_sync, rst_dll, rst_cfg, bg_rst_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_sync = ~clk_sync;
  always #2 clk_cfg  = ~clk_cfg;
  always #3 clk_dll  = ~clk_dll;

  rst_tmr_dist dut (
    .clk_sync(clk_sync), .clk_dll(clk_dll), .clk_cfg(clk_cfg),
    .rst_all_n(rst_all_n), .cmd_all(cmd_all), .cmd_sync(cmd_sync),
    .cmd_dll(cmd_dll), .cmd_cfg(cmd_cfg), .cmd_bg(cmd_bg),
    .rst_sync(rst_sync), .rst_dll(rst_dll), .rst_cfg(rst_cfg), .bg_rst_n(bg_rst_n)
  );

  // active state of domain d: 0 sync, 1 dll, 2 cfg, 3 analog (active low)
  function automatic logic active(input int d);
    case (d)
      0:       return rst_sync;
      1:       return rst_dll;
      2:       return rst_cfg;
      default: return !bg_rst_n;
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [3:0] exp_act);
    for (int d = 0; d < 4; d++) chk(tag, active(d), exp_act[d], $sformatf("domain %0d active", d));
  endtask

  task automatic dom_edge(input int d);
    if (d == 1) @(posedge clk_dll);
    else if (d == 0) @(posedge clk_sync);
    else @(posedge clk_cfg);
  endtask

  // called just after the request is removed; others in quiet must stay idle
  task automatic measure(input int d, input string tag, input logic [3:0] quiet);
    for (int k = 1; k < LAT; k++) begin
      dom_edge(d);
      #1;
      chk(tag, active(d), 1'b1, $sformatf("held after edge %0d", k));
      for (int o = 0; o < 4; o++)
        if (quiet[o]) chk(tag, active(o), 1'b0, $sformatf("domain %0d untouched", o));
    end
    dom_edge(d);
    #1;
    chk(tag, active(d), 1'b0, $sformatf("released after edge %0d", LAT));
  endtask

  task automatic settle();
    repeat (20) @(posedge clk_dll);
    @(negedge clk_cfg);
  endtask

  task automatic t_power_on();
    #1;
    chk_all("R1", 4'b1111);
    #20;
    chk("R7", rst_cfg, 1'b1, "digital reset polarity");
    chk("R7", bg_rst_n, 1'b0, "analog reset polarity");
    @(negedge clk_cfg);
    rst_all_n = 1'b1;
    measure(0, "R8", 4'b0000);
    settle();
    chk_all("R8", 4'b0000);
  endtask

  task automatic t_pin_async();
    rst_all_n = 1'b0;
    #0.5;
    chk_all("R1", 4'b1111);
    @(negedge clk_cfg);
    rst_all_n = 1'b1;
    measure(2, "R8", 4'b0000);
    settle();
  endtask

  task automatic t_cmd(input int d, input string tag);
    case (d)
      0: cmd_sync = 1'b1;
      1: cmd_dll  = 1'b1;
      2: cmd_cfg  = 1'b1;
      default: cmd_bg = 1'b1;
    endcase
    #1;
    chk_all(tag, 4'b0001 << d);
    @(negedge clk_cfg);
    {cmd_sync, cmd_dll, cmd_cfg, cmd_bg} = '0;
    measure(d, tag, ~(4'b0001 << d));
    settle();
    chk_all(tag, 4'b0000);
  endtask

  task automatic t_cmd_all();
    cmd_all = 1'b1;
    #1;
    chk_all("R2", 4'b1111);
    @(negedge clk_cfg);
    cmd_all = 1'b0;
    measure(3, "R2", 4'b0000);
    settle();
    chk_all("R2", 4'b0000);
  endtask

  task automatic t_upset();
    force dut.g_dom[0].u_sync.g_chain[1].u_chain.stage_q = 2'b11;
    repeat (3) begin
      @(posedge clk_sync);
      #1;
      chk("R9", rst_sync, 1'b0, "one chain upset while forced");
    end
    release dut.g_dom[0].u_sync.g_chain[1].u_chain.stage_q;
    repeat (3) begin
      @(posedge clk_sync);
      #1;
      chk("R9", rst_sync, 1'b0, "one chain upset after release");
    end
    settle();
  endtask

  initial begin
    t_power_on();
    t_pin_async();
    t_cmd_all();
    t_cmd(0, "R3");
    t_cmd(1, "R4");
    t_cmd(2, "R5");
    t_cmd(3, "R6");
    t_upset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule